// File: doc/BRIEF.md
# Receive Frame Buffer Segmenter

This block accepts Ethernet frames as a byte stream and scatters each one across a chain of fixed-size receive buffers in a local buffer memory. Every buffer is 258 bytes. Two of those bytes are a housekeeping word and the other 256 hold frame data. A frame always starts in a fresh buffer. When the current buffer is full, the frame continues in the next one. Software can rebuild the frame length by following the chain and adding up the valid-byte counts until it reaches the buffer whose end flag is set.

Buffers are taken in circular index order from a pool of `NUM_BUFS`. The block keeps a free count that starts full. Each buffer the block takes lowers the count by one. Each host release pulse raises it by one, and the raised value is first visible on the following cycle.

If a buffer is needed and none is free, the block pulses an overrun interrupt and discards the rest of that frame up to its end marker. If this happens part-way through a frame, the block rewrites the housekeeping word of the last buffer it wrote so that the word shows the error. It then reports the frame as complete with an error.

The input stream uses valid/ready. `s_ready` is low only while reset is asserted and stays high after that. The source may therefore present a byte on any cycle, and it may leave gaps by holding `s_valid` low. A byte is accepted on each rising clock edge where `s_valid` and `s_ready` are both high. Every output is registered and appears in the cycle after the byte that caused it.

Top module: `rx_seg_top`

## Requirements
- R1: While reset is asserted, `s_ready`, `wr_en`, `hk_en`, `done_valid` and `ovr_irq` are low. After reset the free count equals `NUM_BUFS`, and the first buffer handed out has index 0.
- R2: Byte k of a frame (counting from 0) is written with `wr_buf` set to that frame's buffer number k/256 and `wr_off` = k mod 256. The write appears one cycle after the byte is accepted.
- R3: A frame of length L occupies ceil(L/256) buffers. It starts at offset 0 of a fresh buffer. Its buffers have consecutive indexes that wrap from `NUM_BUFS`-1 to 0.
- R4: The housekeeping word holds the valid count in bits 8:0, the end flag in bit 9 and the error flag in bit 10. Bits 15:11 are zero. When a buffer receives its 256th byte and that byte is not the last of the frame, the word is written with count 256 and end clear. The word for the final buffer is written in the same cycle as the frame's last byte. It carries count L-256*(n-1) and has the end flag set.
- R5: `done_valid` pulses in the same cycle as the final housekeeping write. It carries the frame's first buffer index on `done_head`, with `done_err` low for a frame that completed normally.
- R6: Each buffer taken lowers the free count by one. Each `rel_buf` pulse raises it by one from the next cycle on. When the count is zero, the next buffer request overruns.
- R7: A start byte that arrives with no free buffer pulses `ovr_irq`. It produces no data or housekeeping write and no completion. The frame is discarded through its end marker.
- R8: A buffer request in mid-frame with no free buffer pulses `ovr_irq`. It rewrites the current buffer's word with count 256, end set and error set, and pulses `done_valid` with `done_err` high. The remaining bytes are discarded.
- R9: A byte accepted while no frame is open and without `s_first` is ignored. `s_first` on a byte inside an open frame is treated as ordinary data.
- R10: Once `s_ready` has risen after reset it stays high, so cycles with `s_valid` low only add gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream ready |
| s_data | input | 8 | Stream byte |
| s_first | input | 1 | Byte is the first of a frame |
| s_last | input | 1 | Byte is the last of a frame |
| rel_buf | input | 1 | Host returns one buffer to the pool |
| wr_en | output | 1 | Data byte write strobe |
| wr_buf | output | IDX_W | Buffer index of the data write |
| wr_off | output | 8 | Data offset inside the buffer |
| wr_byte | output | 8 | Data byte |
| hk_en | output | 1 | Housekeeping word write strobe |
| hk_buf | output | IDX_W | Buffer index of the housekeeping write |
| hk_word | output | 16 | Housekeeping word |
| done_valid | output | 1 | Frame completion pulse |
| done_head | output | IDX_W | First buffer index of the completed frame |
| done_err | output | 1 | Completed frame was cut short by overrun |
| ovr_irq | output | 1 | Overrun interrupt pulse |

## Verification
The hardest case to reach is an overrun in mid-frame. It requires the pool to run dry exactly when a full buffer must be followed by another, and the earlier data writes must be left untouched. The stimulus gets there deterministically. It first sends a fixed set of frames with no releases and then sends one long frame that needs more buffers than remain. A frame is then sent on the empty pool, and a burst of releases is counted out to probe the free count. Random traffic with random gaps and sparse releases then produces further overruns at both frame starts and buffer boundaries.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_BUF_BYTES = 256;
  localparam int SEG_CNT_W     = $clog2(SEG_BUF_BYTES + 1);
  localparam int SEG_OFF_W     = $clog2(SEG_BUF_BYTES);
  localparam int SEG_HK_W      = 16;
  localparam int SEG_RSVD_W    = SEG_HK_W - SEG_CNT_W - 2;

  typedef struct packed {
    logic [SEG_RSVD_W-1:0] rsvd;
    logic                  err;
    logic                  eof;
    logic [SEG_CNT_W-1:0]  cnt;
  } seg_hk_t;

  function automatic seg_hk_t seg_mk_hk(input logic [SEG_CNT_W-1:0] c,
                                        input logic e, input logic x);
    seg_hk_t h;
    h.rsvd = '0;
    h.err  = x;
    h.eof  = e;
    h.cnt  = c;
    return h;
  endfunction
endpackage

// File: rtl/seg_alloc.sv
module seg_alloc #(
  parameter int NUM_BUFS = 16,
  parameter int IDX_W    = $clog2(NUM_BUFS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             rel,
  output logic             avail,
  output logic [IDX_W-1:0] next_idx
);
  localparam int FREE_W = $clog2(NUM_BUFS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUFS - 1);

  logic [FREE_W-1:0] free_q;
  logic [IDX_W-1:0]  ptr_q;

  assign avail    = (free_q != '0);
  assign next_idx = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q <= FREE_W'(NUM_BUFS);
      ptr_q  <= '0;
    end else begin
      free_q <= free_q - FREE_W'(take) + FREE_W'(rel);
      if (take) ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
    end
  end

  AST_TAKE_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> free_q != '0); // R6
  AST_FREE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    free_q <= FREE_W'(NUM_BUFS)); // R6
  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take && !rel |=> free_q == $past(free_q) - 1'b1); // R6
endmodule

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_pkg::*;
#(
  parameter int NUM_BUFS = 16,
  parameter int IDX_W    = $clog2(NUM_BUFS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [7:0]           s_data,
  input  logic                 s_first,
  input  logic                 s_last,
  input  logic                 avail,
  input  logic [IDX_W-1:0]     next_idx,
  output logic                 take,
  output logic                 wr_en,
  output logic [IDX_W-1:0]     wr_buf,
  output logic [SEG_OFF_W-1:0] wr_off,
  output logic [7:0]           wr_byte,
  output logic                 hk_en,
  output logic [IDX_W-1:0]     hk_buf,
  output seg_hk_t              hk_word,
  output logic                 done_valid,
  output logic [IDX_W-1:0]     done_head,
  output logic                 done_err,
  output logic                 ovr_irq
);
  localparam logic [SEG_CNT_W-1:0] FULL_CNT = SEG_CNT_W'(SEG_BUF_BYTES);

  logic                 rdy_q, open_q, drop_q;
  logic [IDX_W-1:0]     cur_q, head_q;
  logic [SEG_CNT_W-1:0] cnt_q;
  logic                 acc, full, need_buf;
  logic [SEG_CNT_W-1:0] cnt_inc;

  assign s_ready  = rdy_q;
  assign acc      = s_valid && rdy_q;
  assign full     = (cnt_q == FULL_CNT);
  assign cnt_inc  = cnt_q + 1'b1;
  assign need_buf = acc && ((!open_q && s_first) || (open_q && !drop_q && full));
  assign take     = need_buf && avail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= 1'b0; open_q <= 1'b0; drop_q <= 1'b0;
      cur_q <= '0; head_q <= '0; cnt_q <= '0;
      wr_en <= 1'b0; wr_buf <= '0; wr_off <= '0; wr_byte <= '0;
      hk_en <= 1'b0; hk_buf <= '0; hk_word <= '0;
      done_valid <= 1'b0; done_head <= '0; done_err <= 1'b0;
      ovr_irq <= 1'b0;
    end else begin
      rdy_q      <= 1'b1;
      wr_en      <= 1'b0;
      hk_en      <= 1'b0;
      done_valid <= 1'b0;
      done_err   <= 1'b0;
      ovr_irq    <= 1'b0;
      wr_byte    <= s_data;
      if (acc) begin
        if (!open_q) begin
          if (s_first) begin
            if (avail) begin
              cur_q  <= next_idx;
              head_q <= next_idx;
              cnt_q  <= SEG_CNT_W'(1);
              wr_en  <= 1'b1;
              wr_buf <= next_idx;
              wr_off <= '0;
              if (s_last) begin
                hk_en      <= 1'b1;
                hk_buf     <= next_idx;
                hk_word    <= seg_mk_hk(SEG_CNT_W'(1), 1'b1, 1'b0);
                done_valid <= 1'b1;
                done_head  <= next_idx;
              end else begin
                open_q <= 1'b1;
                drop_q <= 1'b0;
              end
            end else begin
              ovr_irq <= 1'b1;
              open_q  <= !s_last;
              drop_q  <= 1'b1;
            end
          end
        end else if (drop_q) begin
          if (s_last) open_q <= 1'b0;
        end else if (full) begin
          if (avail) begin
            cur_q  <= next_idx;
            cnt_q  <= SEG_CNT_W'(1);
            wr_en  <= 1'b1;
            wr_buf <= next_idx;
            wr_off <= '0;
            if (s_last) begin
              hk_en      <= 1'b1;
              hk_buf     <= next_idx;
              hk_word    <= seg_mk_hk(SEG_CNT_W'(1), 1'b1, 1'b0);
              done_valid <= 1'b1;
              done_head  <= head_q;
              open_q     <= 1'b0;
            end
          end else begin
            ovr_irq    <= 1'b1;
            hk_en      <= 1'b1;
            hk_buf     <= cur_q;
            hk_word    <= seg_mk_hk(FULL_CNT, 1'b1, 1'b1);
            done_valid <= 1'b1;
            done_head  <= head_q;
            done_err   <= 1'b1;
            drop_q     <= 1'b1;
            if (s_last) open_q <= 1'b0;
          end
        end else begin
          cnt_q  <= cnt_inc;
          wr_en  <= 1'b1;
          wr_buf <= cur_q;
          wr_off <= cnt_q[SEG_OFF_W-1:0];
          if (s_last) begin
            hk_en      <= 1'b1;
            hk_buf     <= cur_q;
            hk_word    <= seg_mk_hk(cnt_inc, 1'b1, 1'b0);
            done_valid <= 1'b1;
            done_head  <= head_q;
            open_q     <= 1'b0;
          end else if (cnt_inc == FULL_CNT) begin
            hk_en   <= 1'b1;
            hk_buf  <= cur_q;
            hk_word <= seg_mk_hk(FULL_CNT, 1'b0, 1'b0);
          end
        end
      end
    end
  end

  AST_MID_HK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    hk_en && !hk_word.eof |-> hk_word.cnt == FULL_CNT && !hk_word.err); // R4
  AST_HK_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hk_en |-> hk_word.rsvd == '0 && hk_word.cnt != '0); // R4
  AST_DONE_WITH_HK: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> hk_en && hk_word.eof); // R5
  AST_ERR_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_err |-> ovr_irq && hk_word.err); // R8
  AST_IRQ_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_irq |-> !wr_en); // R7
  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> s_ready); // R10
endmodule

// File: rtl/rx_seg_top.sv
module rx_seg_top
  import seg_pkg::*;
#(
  parameter int NUM_BUFS = 16,
  parameter int IDX_W    = $clog2(NUM_BUFS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_first,
  input  logic             s_last,
  input  logic             rel_buf,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_buf,
  output logic [7:0]       wr_off,
  output logic [7:0]       wr_byte,
  output logic             hk_en,
  output logic [IDX_W-1:0] hk_buf,
  output logic [15:0]      hk_word,
  output logic             done_valid,
  output logic [IDX_W-1:0] done_head,
  output logic             done_err,
  output logic             ovr_irq
);
  logic             take, avail;
  logic [IDX_W-1:0] next_idx;
  seg_hk_t          hk_s;

  assign hk_word = hk_s;

  seg_alloc #(.NUM_BUFS(NUM_BUFS), .IDX_W(IDX_W)) u_alloc (
    .clk(clk), .rst_n(rst_n), .take(take), .rel(rel_buf),
    .avail(avail), .next_idx(next_idx)
  );

  seg_ctrl #(.NUM_BUFS(NUM_BUFS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_first(s_first), .s_last(s_last),
    .avail(avail), .next_idx(next_idx), .take(take),
    .wr_en(wr_en), .wr_buf(wr_buf), .wr_off(wr_off), .wr_byte(wr_byte),
    .hk_en(hk_en), .hk_buf(hk_buf), .hk_word(hk_s),
    .done_valid(done_valid), .done_head(done_head), .done_err(done_err),
    .ovr_irq(ovr_irq)
  );
endmodule

// File: tb/sim_rx_seg_top.sv
`timescale 1ns/1ps
module sim_rx_seg_top;
  localparam int NB = 16;
  localparam int IW = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0, rel_buf = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, wr_en, hk_en, done_valid, done_err, ovr_irq;
  logic [IW-1:0] wr_buf, hk_buf, done_head;
  logic [7:0] wr_off, wr_byte;
  logic [15:0] hk_word;

  always #2.5 clk = ~clk;

  rx_seg_top #(.NUM_BUFS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_first(s_first), .s_last(s_last), .rel_buf(rel_buf),
    .wr_en(wr_en), .wr_buf(wr_buf), .wr_off(wr_off), .wr_byte(wr_byte),
    .hk_en(hk_en), .hk_buf(hk_buf), .hk_word(hk_word),
    .done_valid(done_valid), .done_head(done_head), .done_err(done_err),
    .ovr_irq(ovr_irq)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // reference state, built from the requirements
  bit m_open, m_drop;
  int m_cur, m_cnt, m_head, m_free, m_ptr;
  // expected outputs
  bit e_wr, e_hk, e_done, e_err, e_irq;
  int e_wbuf, e_woff, e_hbuf, e_dhead;
  logic [7:0] e_wbyte;
  logic [15:0] e_hword;
  // per-frame statistics seen at the ports
  int st_bufs, st_last, st_irq, st_done, st_err, st_wr;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] hk(input int c, input bit e, input bit x);
    return {5'b0, x, e, 9'(c)};
  endfunction

  function automatic int grab();
    int i = m_ptr;
    m_ptr = (m_ptr + 1) % NB;
    m_free--;
    return i;
  endfunction

  task automatic clr_stats();
    st_bufs = 0; st_last = -1; st_irq = 0; st_done = 0; st_err = 0; st_wr = 0;
  endtask

  task automatic cyc(input bit v, input logic [7:0] d, input bit f, input bit l,
                     input bit r);
    s_valid = v; s_data = d; s_first = f; s_last = l; rel_buf = r;
    e_wr = 0; e_hk = 0; e_done = 0; e_err = 0; e_irq = 0; e_wbyte = d;
    if (v) begin
      if (!m_open) begin
        if (f) begin
          if (m_free > 0) begin
            m_cur = grab(); m_head = m_cur; m_cnt = 1;
            e_wr = 1; e_wbuf = m_cur; e_woff = 0;
            if (l) begin
              e_hk = 1; e_hbuf = m_cur; e_hword = hk(1, 1, 0);
              e_done = 1; e_dhead = m_head;
            end else begin m_open = 1; m_drop = 0; end
          end else begin
            e_irq = 1; m_open = !l; m_drop = 1;
          end
        end
      end else if (m_drop) begin
        if (l) m_open = 0;
      end else if (m_cnt == 256) begin
        if (m_free > 0) begin
          m_cur = grab(); m_cnt = 1;
          e_wr = 1; e_wbuf = m_cur; e_woff = 0;
          if (l) begin
            e_hk = 1; e_hbuf = m_cur; e_hword = hk(1, 1, 0);
            e_done = 1; e_dhead = m_head; m_open = 0;
          end
        end else begin
          e_irq = 1; e_hk = 1; e_hbuf = m_cur; e_hword = hk(256, 1, 1);
          e_done = 1; e_dhead = m_head; e_err = 1; m_drop = 1;
          if (l) m_open = 0;
        end
      end else begin
        e_wr = 1; e_wbuf = m_cur; e_woff = m_cnt; m_cnt++;
        if (l) begin
          e_hk = 1; e_hbuf = m_cur; e_hword = hk(m_cnt, 1, 0);
          e_done = 1; e_dhead = m_head; m_open = 0;
        end else if (m_cnt == 256) begin
          e_hk = 1; e_hbuf = m_cur; e_hword = hk(256, 0, 0);
        end
      end
    end
    if (r) m_free++;
    @(negedge clk);
    check(wr_en == e_wr && (!e_wr || (wr_buf == IW'(e_wbuf) &&
          wr_off == 8'(e_woff) && wr_byte == e_wbyte)), "R2 data write",
          {wr_en, 4'(wr_buf), wr_off, wr_byte}, {e_wr, 4'(e_wbuf), 8'(e_woff), e_wbyte});
    check(hk_en == e_hk && (!e_hk || (hk_buf == IW'(e_hbuf) && hk_word == e_hword)),
          "R4 housekeeping", {hk_en, 4'(hk_buf), hk_word}, {e_hk, 4'(e_hbuf), e_hword});
    check(done_valid == e_done && (!e_done || (done_head == IW'(e_dhead) &&
          done_err == e_err)), "R5 completion", {done_valid, done_err, 4'(done_head)},
          {e_done, e_err, 4'(e_dhead)});
    check(ovr_irq == e_irq && s_ready, "R7 overrun/R10 ready", {s_ready, ovr_irq},
          {1'b1, e_irq});
    if (wr_en) st_wr++;
    if (wr_en && wr_off == 0) st_bufs++;
    if (hk_en && hk_word[9]) st_last = int'(hk_word[8:0]);
    if (ovr_irq) st_irq++;
    if (done_valid) st_done++;
    if (done_valid && done_err) st_err++;
  endtask

  task automatic frame(input int len, input int gap_pct, input int rel_pct);
    for (int i = 0; i < len; i++) begin
      while (int'($urandom % 100) < gap_pct)
        cyc(0, 8'h00, 0, 0, (m_free < NB) && (int'($urandom % 100) < rel_pct));
      cyc(1, 8'($urandom), i == 0, i == len - 1,
          (m_free < NB) && (int'($urandom % 100) < rel_pct));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lens[5] = '{300, 600, 256, 325, 512};
    int nbuf[5] = '{2, 3, 1, 2, 2};
    int lastc[5] = '{44, 88, 256, 69, 256};
    void'($urandom(32'h5EC0_0B1F));
    m_open = 0; m_drop = 0; m_cur = 0; m_cnt = 0; m_head = 0; m_free = NB; m_ptr = 0;
    repeat (3) @(negedge clk);
    // R1: idle outputs under reset
    check(!s_ready && !wr_en && !hk_en && !done_valid && !ovr_irq, "R1 reset state",
          {s_ready, wr_en, hk_en, done_valid, ovr_irq}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: fixed frame set, no releases, heads 0,2,5,6,8
    for (int k = 0; k < 5; k++) begin
      clr_stats();
      frame(lens[k], 0, 0);
      check(st_bufs == nbuf[k] && st_last == lastc[k] && st_done == 1,
            "R3 buffer chain", {32'(st_bufs), 32'(st_last)}, {32'(nbuf[k]), 32'(lastc[k])});
    end
    // R8: 6 buffers left, 2000-byte frame runs dry after 1536 bytes
    clr_stats();
    frame(2000, 0, 0);
    check(st_irq == 1 && st_err == 1 && st_wr == 1536, "R8 mid-frame overrun",
          {32'(st_irq), 32'(st_wr)}, {32'd1, 32'd1536});
    // R7: empty pool at frame start
    clr_stats();
    frame(5, 0, 0);
    check(st_irq == 1 && st_wr == 0 && st_done == 0, "R7 start overrun",
          {32'(st_irq), 32'(st_wr)}, {32'd1, 32'd0});
    // R9: bytes outside any frame are ignored
    clr_stats();
    for (int i = 0; i < 6; i++) cyc(1, 8'(i), 0, i == 5, 0);
    check(st_wr == 0 && st_irq == 0 && st_done == 0, "R9 stray bytes",
          32'(st_wr), 32'd0);
    // R6: three releases allow exactly three frames
    for (int i = 0; i < 3; i++) cyc(0, 8'h00, 0, 0, 1);
    clr_stats();
    for (int i = 0; i < 4; i++) cyc(1, 8'hA0 + 8'(i), 1, 1, 0);
    check(st_done == 3 && st_irq == 1, "R6 free accounting",
          {32'(st_done), 32'(st_irq)}, {32'd3, 32'd1});
    // refill the pool
    while (m_free < NB) cyc(0, 8'h00, 0, 0, 1);
    // R9: start marker inside an open frame counts as data
    clr_stats();
    cyc(1, 8'h11, 1, 0, 0); cyc(1, 8'h22, 1, 0, 0);
    cyc(1, 8'h33, 0, 0, 0); cyc(1, 8'h44, 0, 1, 0);
    check(st_bufs == 1 && st_last == 4 && st_done == 1, "R9 inner start marker",
          {32'(st_bufs), 32'(st_last)}, {32'd1, 32'd4});
    // R2 R3 R4 R5 R10: random traffic with gaps and sparse releases
    for (int k = 0; k < 40; k++) begin
      frame(1 + int'($urandom % 800), 20, 1);
      repeat (int'($urandom % 4)) cyc(0, 8'h00, 0, 0, 0);
    end
    repeat (3) cyc(0, 8'h00, 0, 0, 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule